// File: doc/BRIEF.md
# Multi-master I2C byte engine with arbitration back-off

This block is the bus-facing engine of an I2C controller for boards where more than one controller can own the two-wire bus. The host gives it one command at a time: open the bus (START, or a repeated START if the bus is already held), shift one byte out, shift one byte in, or close the bus (STOP). The block drives the open-drain clock and data wires through two pull-low enables. It reads both wires back through a two-stage synchronizer. Every command ends with a one-cycle completion pulse and an 8-bit status code, so the host can tell what happened on the bus.

The first byte written after a START is taken as the address byte. Its least significant bit selects the direction, and the status code reports the address outcome. A refused address makes the block close the bus by itself. While it shifts, the block compares every bit it lets float high against the level it reads back. If another controller is holding the line low, the block lets go of both wires and reports the loss. It then refuses to open the bus again until it has seen a STOP on the wires. Clock stretching by a target is honoured: a high phase only starts counting once the clock wire reads high. Each half-period of the clock lasts `div_i` system clocks.

Top module: `i2c_arb_master`

## Requirements
- R1: After reset `status_o` is 0xF8, `busy_o` is 0 and neither `scl_oe_o` nor `sda_oe_o` is asserted. Whenever the engine is idle and does not own the bus, both enables are low.
- R2: A START (`cmd_i`=0) from idle produces SDA falling while SCL is high, and then status 0x08. A START issued while the bus is owned produces status 0x10 (repeated START).
- R3: A WRITE (`cmd_i`=2) right after a START sends the byte MSB first as the address byte. Bit 0 set to 0 means write and 1 means read. An acknowledged address gives status 0x18 (write) or 0x40 (read).
- R4: A refused address gives status 0x20 (write) or 0x48 (read). The engine generates a STOP on its own before it pulses `done_o`, so both wires are released and high at that pulse.
- R5: A WRITE after the address byte shifts the data byte MSB first. It gives status 0x28 when the target acknowledges and 0x30 when it does not.
- R6: A READ (`cmd_i`=3) shifts in 8 bits MSB first into `rdata_o`, then drives the acknowledge bit from `ack_i` (0 = ACK, 1 = NACK). The status is 0x50 after an ACK and 0x58 after a NACK.
- R7: A STOP (`cmd_i`=1) produces SDA rising while SCL is high, then status 0xF8, with both enables low and both wires high.
- R8: If SDA reads low while the engine lets it float for a 1 bit, the status becomes 0x38. Both enables are low in the same cycle as that `done_o` pulse.
- R9: A START requested after a START has been seen on the bus, and before the matching STOP, keeps `busy_o` high and drives neither wire until a STOP appears. The engine then opens the bus and reports 0x08.
- R10: When a target holds SCL low, the bit timing waits for SCL to read high. The delay lengthens the transfer but leaves the data unchanged.
- R11: During a byte, every SCL low phase after the first bit lasts exactly `div_i` system clocks of `scl_oe_o` asserted.
- R12: A command is accepted only when `busy_o` is low. `busy_o` is high from the cycle after acceptance until `done_o`. `done_o` is a single-cycle pulse for each command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_i | input | DIV_W | System clocks per SCL half-period (at least 2) |
| cmd_valid_i | input | 1 | Command strobe, taken when busy_o is low |
| cmd_i | input | 2 | 0 START, 1 STOP, 2 WRITE, 3 READ |
| data_i | input | 8 | Byte to send for WRITE |
| ack_i | input | 1 | Acknowledge to return for READ (1 = NACK) |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 8 | Status code of the last completed command |
| rdata_o | output | 8 | Last byte received |
| scl_i | input | 1 | SCL wire level |
| sda_i | input | 1 | SDA wire level |
| scl_oe_o | output | 1 | Pull SCL low when high |
| sda_oe_o | output | 1 | Pull SDA low when high |

## Verification
Every result of a command (status, received byte, release of the enables) becomes valid on the same clock edge that raises `done_o`. The bench therefore polls `done_o` at falling clock edges and samples all results in that half cycle. It checks the pulse has gone one cycle later. Wire-level results such as the release after a refused address or a STOP are read at that same sample point, because the enables were dropped at least `div_i` cycles earlier. The SCL low-phase width is counted at falling edges between the registered edges of `scl_oe_o`. The back-off case is checked tens of cycles after the request, and again once the competing controller lets go.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;
  localparam logic [1:0] CMD_START = 2'd0;
  localparam logic [1:0] CMD_STOP  = 2'd1;
  localparam logic [1:0] CMD_WRITE = 2'd2;
  localparam logic [1:0] CMD_READ  = 2'd3;

  localparam logic [7:0] STS_START   = 8'h08;
  localparam logic [7:0] STS_RSTART  = 8'h10;
  localparam logic [7:0] STS_AW_ACK  = 8'h18;
  localparam logic [7:0] STS_AW_NACK = 8'h20;
  localparam logic [7:0] STS_DW_ACK  = 8'h28;
  localparam logic [7:0] STS_DW_NACK = 8'h30;
  localparam logic [7:0] STS_ARB     = 8'h38;
  localparam logic [7:0] STS_AR_ACK  = 8'h40;
  localparam logic [7:0] STS_AR_NACK = 8'h48;
  localparam logic [7:0] STS_DR_ACK  = 8'h50;
  localparam logic [7:0] STS_DR_NACK = 8'h58;
  localparam logic [7:0] STS_IDLE    = 8'hF8;

  typedef enum logic [3:0] {
    M_IDLE, M_WAITBUS, M_HOLD,
    M_S_REL, M_S_HI, M_S_LOW,
    M_B_LOW, M_B_HIGH,
    M_P_LOW, M_P_HI, M_P_REL
  } mst_state_t;
endpackage

// File: rtl/i2c_sync.sv
module i2c_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= '1;
        else     chain[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= '1;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic bus_busy
);
  logic scl_d, sda_d;
  logic start_det, stop_det;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign start_det = scl_d && scl_s && sda_d && !sda_s;
  assign stop_det  = scl_d && scl_s && !sda_d && sda_s;

  always_ff @(posedge clk) begin
    if (rst)            bus_busy <= 1'b0;
    else if (start_det) bus_busy <= 1'b1;
    else if (stop_det)  bus_busy <= 1'b0;
  end

  // R9: the bus only turns busy after a start was observed on the wires
  assert_busy_after_start_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_busy) |-> $past(start_det));
endmodule

// File: rtl/i2c_arb_master.sv
module i2c_arb_master
  import i2c_arb_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_i,
  input  logic             cmd_valid_i,
  input  logic [1:0]       cmd_i,
  input  logic [7:0]       data_i,
  input  logic             ack_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [7:0]       status_o,
  output logic [7:0]       rdata_o,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_oe_o,
  output logic             sda_oe_o
);
  localparam int BITS = 9;

  mst_state_t       st;
  logic [DIV_W-1:0] cnt;
  logic [3:0]       bitn;
  logic [BITS-1:0]  sh, rx;
  logic             smp, own, addr_ph, is_rd, dir_rd;
  logic [7:0]       pend;
  logic             scl_s, sda_s, bus_busy;
  logic             tc, drv, take;

  i2c_sync #(.W(2), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d({scl_i, sda_i}), .q({scl_s, sda_s})
  );

  i2c_bus_watch u_watch (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s), .bus_busy(bus_busy)
  );

  assign tc     = (cnt == div_i - DIV_W'(1));
  assign drv    = is_rd ? (bitn == 4'd8) : (bitn != 4'd8);
  assign take   = cmd_valid_i && !busy_o;
  assign busy_o = (st != M_IDLE) && (st != M_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= M_IDLE; cnt <= '0; bitn <= '0; sh <= '1; rx <= '0;
      smp <= 1'b0; own <= 1'b0; addr_ph <= 1'b0; is_rd <= 1'b0; dir_rd <= 1'b0;
      pend <= STS_IDLE; status_o <= STS_IDLE; rdata_o <= '0; done_o <= 1'b0;
      scl_oe_o <= 1'b0; sda_oe_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st)
        M_IDLE: if (take && cmd_i == CMD_START) st <= M_WAITBUS;
        M_WAITBUS: if (!bus_busy) begin st <= M_S_REL; cnt <= '0; end
        M_HOLD: if (take) begin
          cnt <= '0; bitn <= '0;
          case (cmd_i)
            CMD_START: st <= M_S_REL;
            CMD_STOP:  begin st <= M_P_LOW; pend <= STS_IDLE; end
            CMD_WRITE: begin
              st <= M_B_LOW; sh <= {data_i, 1'b1}; is_rd <= 1'b0;
              if (addr_ph) dir_rd <= data_i[0];
            end
            default:   begin st <= M_B_LOW; sh <= {8'hFF, ack_i}; is_rd <= 1'b1; end
          endcase
        end
        M_S_REL: begin
          sda_oe_o <= 1'b0;
          if (tc) begin st <= M_S_HI; scl_oe_o <= 1'b0; cnt <= '0; smp <= 1'b0; end
          else cnt <= cnt + 1'b1;
        end
        M_S_HI: begin
          if (!smp) smp <= scl_s;
          else if (tc) begin st <= M_S_LOW; sda_oe_o <= 1'b1; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        M_S_LOW: begin
          if (tc) begin
            st <= M_HOLD; scl_oe_o <= 1'b1; done_o <= 1'b1;
            status_o <= own ? STS_RSTART : STS_START;
            own <= 1'b1; addr_ph <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        M_B_LOW: begin
          if (cnt == '0) sda_oe_o <= !sh[BITS-1];
          if (tc) begin st <= M_B_HIGH; scl_oe_o <= 1'b0; cnt <= '0; smp <= 1'b0; end
          else cnt <= cnt + 1'b1;
        end
        M_B_HIGH: begin
          if (!smp) begin
            if (scl_s) begin
              smp <= 1'b1;
              rx  <= {rx[BITS-2:0], sda_s};
              if (drv && sh[BITS-1] && !sda_s) begin
                st <= M_IDLE; scl_oe_o <= 1'b0; sda_oe_o <= 1'b0;
                own <= 1'b0; addr_ph <= 1'b0;
                status_o <= STS_ARB; done_o <= 1'b1;
              end
            end
          end else if (tc) begin
            cnt <= '0;
            scl_oe_o <= 1'b1;
            if (bitn == 4'd8) begin
              if (addr_ph) begin
                addr_ph <= 1'b0;
                if (rx[0]) begin
                  st <= M_P_LOW;
                  pend <= dir_rd ? STS_AR_NACK : STS_AW_NACK;
                end else begin
                  st <= M_HOLD; done_o <= 1'b1;
                  status_o <= dir_rd ? STS_AR_ACK : STS_AW_ACK;
                end
              end else begin
                st <= M_HOLD; done_o <= 1'b1;
                if (is_rd) begin
                  rdata_o  <= rx[BITS-1:1];
                  status_o <= rx[0] ? STS_DR_NACK : STS_DR_ACK;
                end else begin
                  status_o <= rx[0] ? STS_DW_NACK : STS_DW_ACK;
                end
              end
            end else begin
              bitn <= bitn + 1'b1;
              sh   <= {sh[BITS-2:0], 1'b1};
              st   <= M_B_LOW;
            end
          end else cnt <= cnt + 1'b1;
        end
        M_P_LOW: begin
          if (cnt == '0) sda_oe_o <= 1'b1;
          if (tc) begin st <= M_P_HI; scl_oe_o <= 1'b0; cnt <= '0; smp <= 1'b0; end
          else cnt <= cnt + 1'b1;
        end
        M_P_HI: begin
          if (!smp) smp <= scl_s;
          else if (tc) begin st <= M_P_REL; sda_oe_o <= 1'b0; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        M_P_REL: begin
          if (tc) begin
            st <= M_IDLE; own <= 1'b0; status_o <= pend; done_o <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= M_IDLE;
      endcase
    end
  end

  // R1: an idle engine never pulls either wire
  assert_idle_release_R1: assert property (@(posedge clk) disable iff (rst)
    (st == M_IDLE) |-> (!scl_oe_o && !sda_oe_o));
  // R4: a refused address is reported only after both wires are let go
  assert_nack_stop_R4: assert property (@(posedge clk) disable iff (rst)
    (done_o && (status_o == STS_AW_NACK || status_o == STS_AR_NACK)) |-> (!scl_oe_o && !sda_oe_o));
  // R8: a lost arbitration releases both wires with the report
  assert_arb_release_R8: assert property (@(posedge clk) disable iff (rst)
    (done_o && status_o == STS_ARB) |-> (!scl_oe_o && !sda_oe_o));
  // R10: while a target stretches, the clock is not pulled again
  assert_stretch_wait_R10: assert property (@(posedge clk) disable iff (rst)
    (st == M_B_HIGH && !smp && !scl_s) |=> !scl_oe_o);
  // R12: completion is a single-cycle pulse
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
endmodule

// File: tb/i2c_arb_master_tb.sv
module i2c_arb_master_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] div_i = 16'd4;
  logic        cmd_valid_i = 1'b0;
  logic [1:0]  cmd_i = 2'd0;
  logic [7:0]  data_i = 8'h00;
  logic        ack_i = 1'b0;
  logic        busy_o, done_o, scl_oe_o, sda_oe_o;
  logic [7:0]  status_o, rdata_o;
  logic        scl_w, sda_w;

  // target model and competing controller
  localparam logic [6:0] SLV_ADDR = 7'h50;
  logic       s_scl_oe = 1'b0, s_sda_oe = 1'b0, o_sda = 1'b0;
  logic       pscl = 1'b1, psda = 1'b1;
  logic       s_act = 1'b0, s_arm = 1'b0, s_isaddr = 1'b0, s_rd = 1'b0, s_mnack = 1'b0;
  logic [3:0] s_bit = '0;
  logic [7:0] s_sh = '0, s_tx = '0, s_last = '0;
  logic [1:0] s_idx = '0;
  logic       s_nack_data = 1'b0;
  int         s_stretch = 0, s_strc = 0;

  int errors = 0, checks = 0, cyc = 0;

  assign scl_w = !(scl_oe_o || s_scl_oe);
  assign sda_w = !(sda_oe_o || s_sda_oe || o_sda);

  always #4 clk = ~clk;

  i2c_arb_master #(.DIV_W(16)) u_dut (
    .clk(clk), .rst(rst), .div_i(div_i), .cmd_valid_i(cmd_valid_i), .cmd_i(cmd_i),
    .data_i(data_i), .ack_i(ack_i), .busy_o(busy_o), .done_o(done_o),
    .status_o(status_o), .rdata_o(rdata_o), .scl_i(scl_w), .sda_i(sda_w),
    .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o)
  );

  function automatic logic [7:0] rom(input logic [1:0] i);
    case (i)
      2'd0: rom = 8'h3C;
      2'd1: rom = 8'hC3;
      2'd2: rom = 8'h5A;
      default: rom = 8'hA5;
    endcase
  endfunction

  always @(posedge clk) begin
    logic match, nrd;
    logic [7:0] nb;
    pscl <= scl_w;
    psda <= sda_w;
    match = (s_sh[7:1] == SLV_ADDR);
    if (s_strc != 0) begin
      s_strc <= s_strc - 1;
      if (s_strc == 1) s_scl_oe <= 1'b0;
    end
    if (pscl && scl_w && psda && !sda_w) begin
      s_act <= 1'b1; s_isaddr <= 1'b1; s_bit <= 4'd0; s_arm <= 1'b0;
      s_sda_oe <= 1'b0; s_rd <= 1'b0; s_idx <= 2'd0;
    end else if (pscl && scl_w && !psda && sda_w) begin
      s_act <= 1'b0; s_sda_oe <= 1'b0;
    end else if (s_act) begin
      if (!pscl && scl_w) begin
        s_arm <= 1'b1;
        if (s_bit < 8) s_sh <= {s_sh[6:0], sda_w};
        else if (s_rd) s_mnack <= sda_w;
      end else if (pscl && !scl_w && s_arm) begin
        if (s_bit == 4'd7) begin
          s_bit <= 4'd8;
          if (s_rd) s_sda_oe <= 1'b0;
          else if (s_isaddr) s_sda_oe <= match;
          else begin s_sda_oe <= !s_nack_data; s_last <= s_sh; end
        end else if (s_bit == 4'd8) begin
          s_bit <= 4'd0;
          nrd = s_isaddr ? (match && s_sh[0]) : s_rd;
          s_rd <= nrd;
          s_isaddr <= 1'b0;
          if (s_isaddr && !match) s_act <= 1'b0;
          if (s_stretch != 0 && (!s_isaddr || match)) begin
            s_strc <= s_stretch; s_scl_oe <= 1'b1;
          end
          if (nrd && (s_isaddr || !s_mnack)) begin
            nb = rom(s_idx);
            s_tx <= nb; s_idx <= s_idx + 2'd1; s_sda_oe <= !nb[7];
          end else s_sda_oe <= 1'b0;
        end else begin
          s_bit <= s_bit + 4'd1;
          if (s_rd) begin s_tx <= {s_tx[6:0], 1'b0}; s_sda_oe <= !s_tx[6]; end
        end
      end
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run exceeded %0d cycles (expected completion)", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done_o && n < 20000) begin
      @(negedge clk);
      n++;
    end
    if (!done_o) chk({req, " done timeout"}, 0, 1);
  endtask

  task automatic issue(input logic [1:0] c, input logic [7:0] d, input logic a);
    @(negedge clk);
    cmd_i = c; data_i = d; ack_i = a; cmd_valid_i = 1'b1;
    @(negedge clk);
    cmd_valid_i = 1'b0;
  endtask

  task automatic run(input logic [1:0] c, input logic [7:0] d, input logic a,
                     input string req, input logic [7:0] exp_sts);
    issue(c, d, a);
    wait_done(req);
    chk(req, status_o, exp_sts);
  endtask

  task automatic t_reset();
    chk("R1 status", status_o, 8'hF8);
    chk("R1 busy", busy_o, 0);
    chk("R1 enables", {scl_oe_o, sda_oe_o}, 0);
  endtask

  task automatic t_write();
    issue(2'd0, 8'h00, 1'b0);
    chk("R12 busy after accept", busy_o, 1);
    wait_done("R2");
    chk("R2 start status", status_o, 8'h08);
    @(negedge clk);
    chk("R12 done single pulse", done_o, 0);
    run(2'd2, 8'hA0, 1'b0, "R3 address write ack", 8'h18);
    run(2'd2, 8'hA5, 1'b0, "R5 data ack", 8'h28);
    chk("R5 target byte", s_last, 8'hA5);
    run(2'd1, 8'h00, 1'b0, "R7 stop status", 8'hF8);
    chk("R7 wires high", {scl_w, sda_w, scl_oe_o, sda_oe_o}, 4'b1100);
  endtask

  task automatic t_addr_nack();
    run(2'd0, 8'h00, 1'b0, "R2 start", 8'h08);
    run(2'd2, 8'h90, 1'b0, "R4 write address refused", 8'h20);
    chk("R4 released after write nack", {scl_w, sda_w, scl_oe_o, sda_oe_o}, 4'b1100);
    run(2'd0, 8'h00, 1'b0, "R2 start", 8'h08);
    run(2'd2, 8'h91, 1'b0, "R4 read address refused", 8'h48);
    chk("R4 released after read nack", {scl_w, sda_w, scl_oe_o, sda_oe_o}, 4'b1100);
  endtask

  task automatic t_read();
    run(2'd0, 8'h00, 1'b0, "R2 start", 8'h08);
    run(2'd2, 8'hA1, 1'b0, "R3 address read ack", 8'h40);
    run(2'd3, 8'h00, 1'b0, "R6 read with ack", 8'h50);
    chk("R6 first byte", rdata_o, 8'h3C);
    run(2'd3, 8'h00, 1'b1, "R6 read with nack", 8'h58);
    chk("R6 second byte", rdata_o, 8'hC3);
    run(2'd1, 8'h00, 1'b0, "R7 stop", 8'hF8);
  endtask

  task automatic t_rstart();
    run(2'd0, 8'h00, 1'b0, "R2 start", 8'h08);
    run(2'd2, 8'hA0, 1'b0, "R3 address write", 8'h18);
    run(2'd2, 8'h11, 1'b0, "R5 data", 8'h28);
    run(2'd0, 8'h00, 1'b0, "R2 repeated start", 8'h10);
    run(2'd2, 8'hA1, 1'b0, "R3 address read after restart", 8'h40);
    run(2'd3, 8'h00, 1'b1, "R6 read nack", 8'h58);
    chk("R6 byte after restart", rdata_o, 8'h3C);
    run(2'd1, 8'h00, 1'b0, "R7 stop", 8'hF8);
  endtask

  task automatic t_data_nack();
    s_nack_data = 1'b1;
    run(2'd0, 8'h00, 1'b0, "R2 start", 8'h08);
    run(2'd2, 8'hA0, 1'b0, "R3 address", 8'h18);
    run(2'd2, 8'h77, 1'b0, "R5 data refused", 8'h30);
    run(2'd1, 8'h00, 1'b0, "R7 stop", 8'hF8);
    s_nack_data = 1'b0;
  endtask

  task automatic t_stretch();
    int t0, d0, d1;
    run(2'd0, 8'h00, 1'b0, "R2 start", 8'h08);
    run(2'd2, 8'hA0, 1'b0, "R3 address", 8'h18);
    t0 = cyc;
    run(2'd2, 8'h66, 1'b0, "R10 base byte", 8'h28);
    d0 = cyc - t0;
    run(2'd1, 8'h00, 1'b0, "R7 stop", 8'hF8);
    s_stretch = 80;
    run(2'd0, 8'h00, 1'b0, "R2 start", 8'h08);
    run(2'd2, 8'hA0, 1'b0, "R10 address stretched", 8'h18);
    t0 = cyc;
    run(2'd2, 8'h99, 1'b0, "R10 stretched byte", 8'h28);
    d1 = cyc - t0;
    chk("R10 stretched data", s_last, 8'h99);
    chk("R10 byte delayed by stretch", (d1 - d0) >= 60, 1);
    run(2'd1, 8'h00, 1'b0, "R7 stop after stretch", 8'hF8);
    s_stretch = 0;
  endtask

  task automatic t_arb();
    run(2'd0, 8'h00, 1'b0, "R2 start", 8'h08);
    o_sda = 1'b1;
    run(2'd2, 8'hA0, 1'b0, "R8 arbitration lost", 8'h38);
    chk("R8 enables released", {scl_oe_o, sda_oe_o}, 0);
    issue(2'd0, 8'h00, 1'b0);
    repeat (60) @(negedge clk);
    chk("R9 waits while bus held", {busy_o, scl_oe_o, sda_oe_o, done_o}, 4'b1000);
    o_sda = 1'b0;
    wait_done("R9");
    chk("R9 start after stop", status_o, 8'h08);
    run(2'd1, 8'h00, 1'b0, "R7 stop", 8'hF8);
  endtask

  task automatic t_divider();
    int n = 0, g = 0;
    div_i = 16'd6;
    run(2'd0, 8'h00, 1'b0, "R2 start", 8'h08);
    run(2'd2, 8'hA0, 1'b0, "R3 address", 8'h18);
    issue(2'd2, 8'h5A, 1'b0);
    while (scl_oe_o && g < 2000) begin @(negedge clk); g++; end
    while (!scl_oe_o && g < 2000) begin @(negedge clk); g++; end
    while (scl_oe_o && g < 2000) begin @(negedge clk); g++; n++; end
    chk("R11 low phase width", n, 6);
    wait_done("R11");
    chk("R11 byte status", status_o, 8'h28);
    chk("R11 byte value", s_last, 8'h5A);
    run(2'd1, 8'h00, 1'b0, "R7 stop", 8'hF8);
    div_i = 16'd4;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write();
    t_addr_nack();
    t_read();
    t_rstart();
    t_data_nack();
    t_stretch();
    t_arb();
    t_divider();
    summary();
    $finish;
  end
endmodule